// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Triggers

This block is one bank of sixteen general-purpose pins behind a small register interface. A host sets the pins it drives, the values they drive, and the pins handed to an alternate function. It can read back the current pin levels.

Every pin can raise an interrupt. Each pin has its own setting for level or edge detection and its own polarity. Detected events latch into a pending register. The bank raises one summary interrupt line whenever a pending pin is not masked. The host clears all pending pins with one write of zero. To catch both edges, the host flips the pin's edge polarity after each event; the hardware does not do this.

Several such banks are placed side by side at a fixed address stride by the surrounding logic. Pin inputs pass through a two-flop synchronizer before they are read or used for detection.

The block has no state machine. Its behaviour is a set of registers, a per-pin detector and a sticky pending register. The named elements are:
- the register-select enumeration;
- the synchronizer stage;
- the detector;
- the pending update, which takes one of three paths each cycle: hold, set by an event, or clear by a zero write.

Top module: `gpio_bank_irq`

## Requirements
- R1: The direction register (offset 0) drives `pin_oe_o`. A bit of 1 makes the pin an output and 0 makes it an input. The register resets to zero.
- R2: The output-value register (offset 1) drives `pin_o`, and the alternate-select register (offset 2) drives `alt_sel_o`. Both reset to zero and read back what was written.
- R3: A read of offset 3 returns the pin levels after a two-flop synchronizer. A pin change becomes visible two clock edges after it is driven. Writes to offset 3 are ignored.
- R4: The mask register (offset 4) resets to all ones. `irq_o` is high exactly when some pending bit has its mask bit at 0.
- R5: The trigger-type register (offset 5) selects edge mode for a pin when its bit is 1. In edge mode, edge-polarity bit (offset 6) 1 means a rising edge sets pending and 0 means a falling edge sets pending. Pending is set on the third clock edge after the pin is driven.
- R6: In level mode (trigger-type bit 0), level-polarity bit (offset 7) 1 means active-high and 0 means active-low. The pending bit is set again on every cycle while the synchronized level is active.
- R7: A write of zero to the pending register (offset 8) clears all pending bits. A nonzero write to offset 8 has no effect.
- R8: An event detected in the same cycle as a clearing write stays pending after that write.
- R9: Pending bits latch even while masked, and stay set until cleared.
- R10: Reads of unmapped offsets 9 to 15 return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| pin_i | input | 16 | Pin levels from the pads |
| pin_o | output | 16 | Values driven on output pins |
| pin_oe_o | output | 16 | Per-pin output enable |
| alt_sel_o | output | 16 | Per-pin alternate-function select |
| irq_o | output | 1 | Summary interrupt of the bank |

## Verification
The hardest case is a pin event whose detection lands on the same clock edge as a clearing write. Detection trails the pin change by three edges, so the stimulus drives the pin, idles one cycle, and issues the zero write on the following cycle.

The bench also needs quiet windows to observe edge mode. After reset every pin is in active-low level mode, so the pending register refills on every cycle. The bench first sets the level polarity to match the idle pin levels, then clears pending, and only then switches pins to edge mode.

A long random phase mixes writes to every offset with random pin activity. A cycle-level model built from the requirements checks each cycle's read data and outputs.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_DIR   = 4'd0,
        RA_OUT   = 4'd1,
        RA_ALT   = 4'd2,
        RA_PINS  = 4'd3,
        RA_MASK  = 4'd4,
        RA_TRIG  = 4'd5,
        RA_EDGE  = 4'd6,
        RA_LEVEL = 4'd7,
        RA_PEND  = 4'd8
    } reg_addr_e;
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[k] <= '0;
                end else begin
                    stage_q[k] <= (k == 0) ? async_i : stage_q[(k == 0) ? 0 : k-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpb_trigger.sv
module gpb_trigger #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    input  logic [WIDTH-1:0] edge_mode_i,
    input  logic [WIDTH-1:0] rise_sel_i,
    input  logic [WIDTH-1:0] high_sel_i,
    output logic [WIDTH-1:0] hit_o
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level_i;
    end

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_pin
            logic rise, fall;
            assign rise = level_i[i] & ~prev_q[i];
            assign fall = ~level_i[i] & prev_q[i];
            always_comb begin
                unique case (edge_mode_i[i])
                    1'b1:    hit_o[i] = rise_sel_i[i] ? rise : fall;
                    default: hit_o[i] = high_sel_i[i] ? level_i[i] : ~level_i[i];
                endcase
            end
        end
    endgenerate

    // R5: an edge-mode hit requires the synchronized level to differ from the last cycle
    p_edge_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(hit_o & edge_mode_i)) |=> ((($past(hit_o) & $past(edge_mode_i)) & ~($past(level_i) ^ $past(prev_q))) == '0));
endmodule

// File: rtl/gpb_regs.sv
module gpb_regs
    import gpb_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [WIDTH-1:0]  wdata_i,
    output logic [WIDTH-1:0]  rdata_o,
    input  logic [WIDTH-1:0]  pins_sync_i,
    input  logic [WIDTH-1:0]  hit_i,
    output logic [WIDTH-1:0]  dir_o,
    output logic [WIDTH-1:0]  out_o,
    output logic [WIDTH-1:0]  alt_o,
    output logic [WIDTH-1:0]  mask_o,
    output logic [WIDTH-1:0]  edge_mode_o,
    output logic [WIDTH-1:0]  rise_sel_o,
    output logic [WIDTH-1:0]  high_sel_o,
    output logic [WIDTH-1:0]  pend_o
);
    logic clear_req;
    logic [WIDTH-1:0] pend_keep;

    assign clear_req = we_i && (addr_i == RA_PEND) && (wdata_i == '0);
    assign pend_keep = clear_req ? '0 : pend_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_o       <= '0;
            out_o       <= '0;
            alt_o       <= '0;
            mask_o      <= '1;
            edge_mode_o <= '0;
            rise_sel_o  <= '0;
            high_sel_o  <= '0;
        end else if (we_i) begin
            unique case (addr_i)
                RA_DIR:   dir_o       <= wdata_i;
                RA_OUT:   out_o       <= wdata_i;
                RA_ALT:   alt_o       <= wdata_i;
                RA_MASK:  mask_o      <= wdata_i;
                RA_TRIG:  edge_mode_o <= wdata_i;
                RA_EDGE:  rise_sel_o  <= wdata_i;
                RA_LEVEL: high_sel_o  <= wdata_i;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_o <= '0;
        else        pend_o <= pend_keep | hit_i;
    end

    always_comb begin
        unique case (addr_i)
            RA_DIR:   rdata_o = dir_o;
            RA_OUT:   rdata_o = out_o;
            RA_ALT:   rdata_o = alt_o;
            RA_PINS:  rdata_o = pins_sync_i;
            RA_MASK:  rdata_o = mask_o;
            RA_TRIG:  rdata_o = edge_mode_o;
            RA_EDGE:  rdata_o = rise_sel_o;
            RA_LEVEL: rdata_o = high_sel_o;
            RA_PEND:  rdata_o = pend_o;
            default:  rdata_o = '0;
        endcase
    end

    // R1: a write to the direction offset is visible on the next cycle
    p_dir_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == RA_DIR) |=> (dir_o == $past(wdata_i)));

    // R7: a zero write with no concurrent event leaves nothing pending
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_req && hit_i == '0) |=> (pend_o == '0));

    // R9: without a clearing write, pending bits never drop, regardless of mask
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_req |=> ((pend_o & $past(pend_o)) == $past(pend_o)));

    // R8: an event always lands in pending, even during a clear
    p_hit_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit_i) |=> ((pend_o & $past(hit_i)) == $past(hit_i)));
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq
    import gpb_pkg::*;
#(
    parameter int N_PINS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [N_PINS-1:0] bus_wdata,
    output logic [N_PINS-1:0] bus_rdata,
    input  logic [N_PINS-1:0] pin_i,
    output logic [N_PINS-1:0] pin_o,
    output logic [N_PINS-1:0] pin_oe_o,
    output logic [N_PINS-1:0] alt_sel_o,
    output logic              irq_o
);
    logic [N_PINS-1:0] pins_sync, hit, mask, edge_mode, rise_sel, high_sel, pend;

    gpb_sync #(.WIDTH(N_PINS), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pin_i), .sync_o(pins_sync)
    );

    gpb_trigger #(.WIDTH(N_PINS)) u_trig (
        .clk(clk), .rst_n(rst_n), .level_i(pins_sync),
        .edge_mode_i(edge_mode), .rise_sel_i(rise_sel), .high_sel_i(high_sel),
        .hit_o(hit)
    );

    gpb_regs #(.WIDTH(N_PINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .we_i(bus_we),
        .wdata_i(bus_wdata), .rdata_o(bus_rdata), .pins_sync_i(pins_sync),
        .hit_i(hit), .dir_o(pin_oe_o), .out_o(pin_o), .alt_o(alt_sel_o),
        .mask_o(mask), .edge_mode_o(edge_mode), .rise_sel_o(rise_sel),
        .high_sel_o(high_sel), .pend_o(pend)
    );

    assign irq_o = |(pend & ~mask);

    // R4: an unmasked pending bit held for two cycles keeps the line asserted
    p_irq_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend & ~mask) && !bus_we) |=> irq_o);
endmodule

// File: tb/gpio_bank_irq_tb.sv
module gpio_bank_irq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        we = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata, pin_i = '0, pin_o, pin_oe, alt_sel;
    logic        irq;
    int          n_checks = 0, n_errors = 0;
    bit          done = 0;

    logic [15:0] m_dir, m_out, m_alt, m_mask, m_trig, m_edge, m_lvl, m_pend, m_s1, m_s2, m_sd;

    always #2 clk = ~clk;

    gpio_bank_irq u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rdata), .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe),
        .alt_sel_o(alt_sel), .irq_o(irq)
    );

    function automatic logic [15:0] exp_rd(input logic [3:0] a);
        case (a)
            4'd0: return m_dir;
            4'd1: return m_out;
            4'd2: return m_alt;
            4'd3: return m_s2;
            4'd4: return m_mask;
            4'd5: return m_trig;
            4'd6: return m_edge;
            4'd7: return m_lvl;
            4'd8: return m_pend;
            default: return 16'h0;
        endcase
    endfunction

    function automatic logic [15:0] exp_hit();
        logic [15:0] h;
        for (int i = 0; i < 16; i++)
            h[i] = m_trig[i] ? (m_edge[i] ? (m_s2[i] & ~m_sd[i]) : (~m_s2[i] & m_sd[i]))
                             : (m_lvl[i] ? m_s2[i] : ~m_s2[i]);
        return h;
    endfunction

    task automatic cmp(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check(input string tag);
        cmp(tag, "rdata", rdata, exp_rd(addr));
        cmp(tag, "pin_o", pin_o, m_out);
        cmp(tag, "pin_oe", pin_oe, m_dir);
        cmp(tag, "alt_sel", alt_sel, m_alt);
        cmp(tag, "irq", {15'd0, irq}, {15'd0, |(m_pend & ~m_mask)});
    endtask

    // one clock: drive at negedge, advance model, return at next negedge
    task automatic cyc(input logic [3:0] a, input logic w, input logic [15:0] d, input logic [15:0] p);
        logic [15:0] h, np;
        addr = a; we = w; wdata = d; pin_i = p;
        h  = exp_hit();
        np = ((w && a == 4'd8 && d == 16'h0) ? 16'h0 : m_pend) | h;
        @(posedge clk);
        @(negedge clk);
        m_pend = np;
        m_sd = m_s2; m_s2 = m_s1; m_s1 = p;
        if (w) begin
            case (a)
                4'd0: m_dir = d;
                4'd1: m_out = d;
                4'd2: m_alt = d;
                4'd4: m_mask = d;
                4'd5: m_trig = d;
                4'd6: m_edge = d;
                4'd7: m_lvl = d;
                default: ;
            endcase
        end
        we = 1'b0;
    endtask

    initial begin
        #(4ns * 200000);
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] p;
        void'($urandom(32'd1234));
        m_dir = 0; m_out = 0; m_alt = 0; m_mask = 16'hffff; m_trig = 0; m_edge = 0;
        m_lvl = 0; m_pend = 0; m_s1 = 0; m_s2 = 0; m_sd = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state
        addr = 4'd4; #0.1; check("R4 reset mask");
        cyc(4'd0, 0, 0, 0); check("R1 reset dir");
        cyc(4'd8, 0, 0, 0); check("R9 masked pending after reset");
        // R1, R2 register access
        cyc(4'd0, 1, 16'ha5a5, 0); check("R1");
        cyc(4'd1, 1, 16'h1234, 0); check("R2 out");
        cyc(4'd2, 1, 16'h00ff, 0); check("R2 alt");
        // R3 read-only pins, two-edge latency
        cyc(4'd3, 1, 16'hffff, 16'hbeef); check("R3 stage1");
        cyc(4'd3, 0, 0, 16'hbeef); check("R3 visible");
        // R10 unmapped
        cyc(4'd9, 1, 16'hffff, 16'hbeef); check("R10 write");
        cyc(4'd15, 0, 0, 16'hbeef); check("R10 read");
        // quiesce: level polarity matches idle pins, then clear
        cyc(4'd7, 1, 16'hbeef, 16'hbeef); check("R6 polarity");
        cyc(4'd8, 1, 16'h0, 16'hbeef); check("R7 clear");
        cyc(4'd8, 0, 0, 16'hbeef); check("R7 stays clear");
        cyc(4'd8, 1, 16'h0040, 16'hbeef); check("R7 nonzero ignored");
        // R6 refill every cycle
        cyc(4'd7, 1, 16'h0000, 16'hbeef); check("R6 flip");
        cyc(4'd8, 0, 0, 16'hbeef); check("R6 refilled");
        cyc(4'd8, 1, 16'h0, 16'hbeef); check("R6 clear with active level");
        // R4 unmask
        cyc(4'd4, 1, 16'h0f00, 16'hbeef); check("R4 unmask");
        // R5 edge mode
        cyc(4'd5, 1, 16'hffff, 16'h0000);
        cyc(4'd6, 1, 16'h00ff, 16'h0000);
        cyc(4'd8, 1, 16'h0, 16'h0000); check("R5 clear");
        cyc(4'd8, 0, 0, 16'hffff);
        cyc(4'd8, 0, 0, 16'hffff); check("R5 not yet");
        cyc(4'd8, 0, 0, 16'hffff); check("R5 rising");
        cyc(4'd8, 1, 16'h0, 16'h0000);
        cyc(4'd8, 0, 0, 16'h0000);
        cyc(4'd8, 0, 0, 16'h0000); check("R5 falling");
        // R8 event coinciding with clear
        cyc(4'd8, 1, 16'h0, 16'h0000); check("R8 cleared");
        cyc(4'd8, 0, 0, 16'h0101);
        cyc(4'd8, 0, 0, 16'h0101);
        cyc(4'd8, 1, 16'h0, 16'h0101); check("R8 kept");
        // random phase
        for (int n = 0; n < 4000; n++) begin
            logic [3:0] a;
            a = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(9, 15)) : 4'($urandom_range(0, 8));
            p = ($urandom_range(0, 3) == 0) ? 16'($urandom) : pin_i;
            cyc(a, 1'($urandom_range(0, 1)), ($urandom_range(0, 2) == 0) ? 16'h0 : 16'($urandom), p);
            check("R3 random");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule